// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block derives the 16x oversampling tick for a serial receiver and transmitter from a fast peripheral reference clock. The reference first passes through an integer pre-divider with a 3-bit select. The divided rate then drives a fractional rate multiplier. On every divided-reference cycle an accumulator gains the numerator. Each time it reaches the denominator it gives back the denominator and produces one tick. Software writes both factors as value minus one. To reach a baud rate B from a divided reference F, it programs numerator = B/100 - 1 and denominator = F/1600 - 1.

A second counter runs from the same divided reference and issues a one-millisecond tick. Its period comes from a reload register that software sets to F/1000. A small controller follows the module enable through three named states. In HALT the enable is low and all counting is held clear. The transition HALT to PRIME is taken when the enable rises, and PRIME spends one cycle starting every counter from a clean phase. The transition PRIME to RUN follows while the enable stays high, and RUN produces ticks. Every state returns to HALT as soon as the enable falls.

Configuration is loaded through a single-cycle write port with a 2-bit register select. Writes are accepted whether the enable is high or low.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset the outputs are low, the controller is in HALT and the registers hold their defaults: pre-divider code 5 (divide by 1), numerator field 0, denominator field 0, millisecond reload 0. Enabling with these defaults gives a 16x tick and a millisecond tick on every clock from the third rising edge after the enable is first seen high.
- R2: The pre-divider code selects the divide ratio as follows: code 0 gives 6, code 1 gives 5, code 2 gives 4, code 3 gives 3, code 4 gives 2, code 5 gives 1 and code 6 gives 7. Code 7 is reserved and divides by 1.
- R3: Registers hold the numerator minus one (n) and the denominator minus one (d). Over a window started by enabling, the 16x tick count is within two ticks of window / ratio × (n+1)/(d+1).
- R4: When n is greater than or equal to d, a 16x tick is issued on every divided-reference cycle.
- R5: A write to the numerator or denominator register clears the accumulator. With divide-by-1, the first tick after the write then appears exactly d+1 clock edges after the write edge, whatever the earlier phase was.
- R6: The millisecond tick is issued once every L divided-reference cycles, where L is the reload value. A reload of 0 behaves as 1. Over a window started by enabling, the count is within two ticks of the ideal.
- R7: While the enable is low, no tick is issued. Both outputs are low from the first clock edge that samples the enable low. Ticks resume through PRIME after the enable rises again.
- R8: Write select encoding: 0 is the pre-divider code (data bits 2:0), 1 is the numerator field, 2 is the denominator field and 3 is the millisecond reload. Each write takes effect on the clock edge that samples it, including while the enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Module enable; low stops all ticks |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select (0 divider, 1 numerator, 2 denominator, 3 ms reload) |
| wr_data_i | input | REG_W | Write data |
| tick16_o | output | 1 | 16x oversampling tick, one clock wide per event |
| ms_tick_o | output | 1 | One-millisecond tick, one clock wide per event |

## Verification
The hardest situation to reach from the ports is a numerator or denominator write that lands while the accumulator holds a non-zero remainder. Only such a write tells a proper clear apart from a design that keeps the old phase. The stimulus first waits for a tick at a known ratio and then lets a fixed number of divided cycles pass, so the remainder is known to be part-way. It then rewrites the denominator and counts edges to the next tick. With the clear the tick comes a full period later; without it, the tick arrives early. Rate behaviour is checked over long windows for every pre-divider code, including the reserved one and a numerator above the denominator.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_PRIME = 2'd1,
        ST_RUN   = 2'd2
    } gen_state_t;

    localparam logic [1:0] SEL_DIV  = 2'd0;
    localparam logic [1:0] SEL_NUM  = 2'd1;
    localparam logic [1:0] SEL_DEN  = 2'd2;
    localparam logic [1:0] SEL_MS   = 2'd3;

    localparam logic [2:0] DIV_CODE_RESET = 3'd5;

endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs #(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [2:0]       div_code_o,
    output logic [REG_W-1:0] num_m1_o,
    output logic [REG_W-1:0] den_m1_o,
    output logic [REG_W-1:0] ms_reload_o,
    output logic             acc_clear_o
);
    import baud_gen_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_code_o  <= DIV_CODE_RESET;
            num_m1_o    <= '0;
            den_m1_o    <= '0;
            ms_reload_o <= '0;
        end else if (wr_en_i) begin
            unique case (wr_sel_i)
                SEL_DIV: div_code_o  <= wr_data_i[2:0];
                SEL_NUM: num_m1_o    <= wr_data_i;
                SEL_DEN: den_m1_o    <= wr_data_i;
                SEL_MS:  ms_reload_o <= wr_data_i;
                default: ;
            endcase
        end
    end

    // A ratio change restarts the fractional phase
    assign acc_clear_o = wr_en_i && ((wr_sel_i == SEL_NUM) || (wr_sel_i == SEL_DEN));

endmodule

// File: rtl/baud_prediv.sv
module baud_prediv #(
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic [2:0] code_i,
    output logic       ce_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    // Terminal count is ratio minus one; the code table is not monotonic
    always_comb begin
        case (code_i)
            3'd0:    last = CNT_W'(5);
            3'd1:    last = CNT_W'(4);
            3'd2:    last = CNT_W'(3);
            3'd3:    last = CNT_W'(2);
            3'd4:    last = CNT_W'(1);
            3'd5:    last = CNT_W'(0);
            3'd6:    last = CNT_W'(6);
            default: last = CNT_W'(0);
        endcase
    end

    assign ce_o = !clr_i && (cnt_q >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (clr_i || ce_o) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc #(
    parameter int REG_W = 16,
    localparam int ACC_W = REG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             acc_clear_i,
    input  logic             ce_i,
    input  logic [REG_W-1:0] num_m1_i,
    input  logic [REG_W-1:0] den_m1_i,
    output logic             tick_o,
    output logic [ACC_W-1:0] acc_o
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] limit;
    logic             saturate;
    logic             hit;

    // Without saturation num < den, so sum stays below twice the limit
    assign saturate = (num_m1_i >= den_m1_i);
    assign sum      = acc_q + ACC_W'(num_m1_i) + ACC_W'(1);
    assign limit    = ACC_W'(den_m1_i) + ACC_W'(1);
    assign hit      = saturate || (sum >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else if (clr_i || acc_clear_i) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else if (ce_i) begin
            tick_o <= hit;
            if (saturate)  acc_q <= '0;
            else if (hit)  acc_q <= sum - limit;
            else           acc_q <= sum;
        end else begin
            tick_o <= 1'b0;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/baud_ms_timer.sv
module baud_ms_timer #(
    parameter int REG_W = 16,
    localparam int NXT_W = REG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             ce_i,
    input  logic [REG_W-1:0] reload_i,
    output logic             tick_o
);
    logic [REG_W-1:0] cnt_q;
    logic [NXT_W-1:0] nxt;
    logic             wrap;

    assign nxt  = NXT_W'(cnt_q) + NXT_W'(1);
    assign wrap = (nxt >= NXT_W'(reload_i));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (clr_i) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (ce_i) begin
            tick_o <= wrap;
            cnt_q  <= wrap ? '0 : nxt[REG_W-1:0];
        end else begin
            tick_o <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
    parameter int REG_W = 16,
    localparam int ACC_W = REG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic             tick16_o,
    output logic             ms_tick_o
);
    import baud_gen_pkg::*;

    gen_state_t       state_q, state_d;
    logic             run;
    logic             clr;
    logic [2:0]       div_code_q;
    logic [REG_W-1:0] num_m1_q;
    logic [REG_W-1:0] den_m1_q;
    logic [REG_W-1:0] ms_reload_q;
    logic             acc_clear;
    logic             div_ce;
    logic [ACC_W-1:0] acc_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (en_i) state_d = ST_PRIME;
            ST_PRIME: state_d = en_i ? ST_RUN : ST_HALT;
            ST_RUN:   if (!en_i) state_d = ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    // Outputs of the controller: a low enable silences the datapath at once
    always_comb begin
        run = 1'b0;
        unique case (state_q)
            ST_HALT:  run = 1'b0;
            ST_PRIME: run = 1'b0;
            ST_RUN:   run = en_i;
            default:  run = 1'b0;
        endcase
        clr = !run;
    end

    baud_cfg_regs #(.REG_W(REG_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_sel_i    (wr_sel_i),
        .wr_data_i   (wr_data_i),
        .div_code_o  (div_code_q),
        .num_m1_o    (num_m1_q),
        .den_m1_o    (den_m1_q),
        .ms_reload_o (ms_reload_q),
        .acc_clear_o (acc_clear)
    );

    baud_prediv #(.CNT_W(3)) u_prediv (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .code_i (div_code_q),
        .ce_o   (div_ce)
    );

    baud_frac_acc #(.REG_W(REG_W)) u_frac (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr),
        .acc_clear_i (acc_clear),
        .ce_i        (div_ce),
        .num_m1_i    (num_m1_q),
        .den_m1_i    (den_m1_q),
        .tick_o      (tick16_o),
        .acc_o       (acc_q)
    );

    baud_ms_timer #(.REG_W(REG_W)) u_ms (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .ce_i     (div_ce),
        .reload_i (ms_reload_q),
        .tick_o   (ms_tick_o)
    );

endmodule

// File: rtl/uart_baud_gen_chk.sv
module uart_baud_gen_chk #(
    parameter int REG_W = 16,
    localparam int ACC_W = REG_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             tick16_o,
    input logic             ms_tick_o,
    input logic             div_ce,
    input logic             run,
    input logic             acc_clear,
    input logic [2:0]       div_code_q,
    input logic [REG_W-1:0] den_m1_q,
    input logic [ACC_W-1:0] acc_q
);

    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> (!tick16_o && !ms_tick_o)); // R7

    AST_UNITY_DIVIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ((div_code_q == 3'd5) || (div_code_q == 3'd7))) |-> div_ce); // R2

    AST_TICK_FROM_CE: assert property (@(posedge clk) disable iff (!rst_n)
        tick16_o |-> $past(div_ce)); // R3

    AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= ACC_W'(den_m1_q)); // R3

    AST_RATIO_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_clear) |-> (acc_q == '0)); // R5

    AST_MS_FROM_CE: assert property (@(posedge clk) disable iff (!rst_n)
        ms_tick_o |-> $past(div_ce)); // R6

endmodule

bind uart_baud_gen uart_baud_gen_chk #(.REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .tick16_o   (tick16_o),
    .ms_tick_o  (ms_tick_o),
    .div_ce     (div_ce),
    .run        (run),
    .acc_clear  (acc_clear),
    .div_code_q (div_code_q),
    .den_m1_q   (den_m1_q),
    .acc_q      (acc_q)
);

// File: tb/sim_uart_baud_gen.sv
module sim_uart_baud_gen;
    localparam int CLK_PERIOD = 10;
    localparam int REG_W      = 16;
    localparam int NVEC       = 8;

    // code, numerator field, denominator field, ms reload, window in clocks
    localparam int VEC [NVEC][5] = '{
        '{5, 0,  3,  100, 4000},
        '{4, 2,  6,  50,  4200},
        '{3, 11, 24, 70,  6300},
        '{2, 4,  4,  25,  4000},
        '{1, 6,  2,  0,   5000},
        '{0, 0,  1,  20,  6000},
        '{6, 2,  9,  10,  7000},
        '{7, 1,  12, 39,  3900}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_i = 1'b0;
    logic             wr_en_i = 1'b0;
    logic [1:0]       wr_sel_i = 2'd0;
    logic [REG_W-1:0] wr_data_i = '0;
    logic             tick16_o;
    logic             ms_tick_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_baud_gen #(.REG_W(REG_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .tick16_o  (tick16_o),
        .ms_tick_o (ms_tick_o)
    );

    function automatic int ratio_of(int code);
        case (code)
            0: return 6;
            1: return 5;
            2: return 4;
            3: return 3;
            4: return 2;
            6: return 7;
            default: return 1;
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, int data);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_sel_i  = sel;
        wr_data_i = REG_W'(data);
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic run_window(int w, output int nt, output int nm);
        nt = 0;
        nm = 0;
        @(negedge clk);
        en_i = 1'b1;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            nt += int'(tick16_o);
            nm += int'(ms_tick_o);
        end
        en_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            nt += int'(tick16_o);
            nm += int'(ms_tick_o);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int nt, nm, q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: silent after reset while disabled
        nt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            nt += int'(tick16_o) + int'(ms_tick_o);
        end
        check(nt == 0, "R1 idle after reset", nt, 0);

        // R1: defaults tick every clock from the third edge after enable
        en_i = 1'b1;
        @(negedge clk);
        check(tick16_o == 1'b0, "R1 no tick in HALT->PRIME", int'(tick16_o), 0);
        @(negedge clk);
        check(tick16_o == 1'b0, "R1 no tick in PRIME->RUN", int'(tick16_o), 0);
        nt = 0;
        nm = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            nt += int'(tick16_o);
            nm += int'(ms_tick_o);
        end
        check(nt == 20, "R1 default 16x rate", nt, 20);
        check(nm == 20, "R1 default ms rate", nm, 20);

        // R7: ticks stop on the first edge that sees the enable low
        en_i = 1'b0;
        nt = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            nt += int'(tick16_o) + int'(ms_tick_o);
        end
        check(nt == 0, "R7 silent while disabled", nt, 0);

        // R2 R3 R4 R6 R8: rate table, written while disabled
        for (int v = 0; v < NVEC; v++) begin
            int r, ce_n, exp_t, exp_m, ld;
            wr(2'd0, VEC[v][0]);
            wr(2'd1, VEC[v][1]);
            wr(2'd2, VEC[v][2]);
            wr(2'd3, VEC[v][3]);
            run_window(VEC[v][4], nt, nm);
            r    = ratio_of(VEC[v][0]);
            ce_n = VEC[v][4] / r;
            if (VEC[v][1] >= VEC[v][2]) exp_t = ce_n;  // R4
            else exp_t = ce_n * (VEC[v][1] + 1) / (VEC[v][2] + 1);
            ld    = (VEC[v][3] == 0) ? 1 : VEC[v][3];
            exp_m = ce_n / ld;
            check((nt - exp_t <= 2) && (exp_t - nt <= 2), "R2/R3 16x rate", nt, exp_t);
            check((nm - exp_m <= 2) && (exp_m - nm <= 2), "R6 ms rate", nm, exp_m);
            repeat (2) @(negedge clk);
        end

        // R5: rewrite the denominator mid-phase, next tick a full period later
        wr(2'd0, 5);
        wr(2'd1, 0);
        wr(2'd2, 9);
        @(negedge clk);
        en_i = 1'b1;
        q = 0;
        while (!tick16_o && q < 100) begin
            @(negedge clk);
            q++;
        end
        check(tick16_o == 1'b1, "R5 reference tick seen", int'(tick16_o), 1);
        repeat (4) @(negedge clk);
        wr(2'd2, 9);
        q = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (tick16_o && q == 0) q = k;
        end
        check(q == 10, "R5 phase cleared by write", q, 10);

        // R8: a write while enabled takes effect at once (denominator 0 -> every clock)
        wr(2'd2, 0);
        nt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            nt += int'(tick16_o);
        end
        check(nt == 10, "R8 live write applied", nt, 10);
        en_i = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule